// File: doc/BRIEF.md
# Cached DRAM Line-Buffer Controller

This block models, at cycle level, a nibble-wide DRAM array with a small direct-mapped SRAM cache in front of it. Clients issue single-nibble reads and writes over a valid/ready request channel. Each accepted request produces exactly one response pulse. A read response carries the stored nibble. A write response echoes the nibble that was written.

When a request hits in the SRAM, it completes in one cycle. On a miss, the whole 16-nibble line moves in a single 64-bit copy. The line goes from the DRAM array into the SRAM, and a dirty victim line is first copied back the same way. The requested nibble comes back after the miss latency. The DRAM array stays occupied for its longer cycle. During that time the SRAM keeps serving hits, and any further miss is held off until the array is free.

The address width is a parameter. The default is kept small so that the modelled array stays compact. Setting it to 20 gives the full one-million-nibble array.

Top module: `cdram_ctrl`

## Requirements
- R1: Every read returns the nibble most recently written to that address. An address that has never been written returns 0.
- R2: A request that hits in the SRAM is answered in the cycle after it is accepted: resp_valid is high on the next clock edge.
- R3: A miss is answered 7 cycles after acceptance. req_ready stays low until the answer appears, and resp_valid stays low before it.
- R4: After a miss, every other nibble of the same 16-nibble line hits. A line is selected by address bits [11:4], and bits [3:0] select the nibble within it.
- R5: Accepting a miss drives dram_busy high for exactly 28 consecutive cycles. Hits are still accepted while dram_busy is high.
- R6: A miss is not accepted while dram_busy is high. req_ready is held low for that miss until dram_busy falls.
- R7: A write marks its line dirty. When a dirty line is replaced, its full contents are stored back to the DRAM array before the new line is loaded, so no written data is lost.
- R8: Reset leaves no line valid and no line dirty, and the DRAM array holds zeros. After reset, resp_valid is low, dram_busy is low and req_ready is high. The first access to any line is a miss.
- R9: A write produces a response with the same latency a read would have (hit or miss), and resp_rdata equals the written nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Nibble address: tag, line index [11:4], offset [3:0] |
| req_wdata | input | 4 | Write nibble |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 4 | Read data, or the echoed write data |
| dram_busy | output | 1 | DRAM array cycle in progress |

## Verification
A corrupted tag or valid bit shows up in the response latency: a line that should hit answers in 7 cycles instead of 1, or the reverse, from the very next request to that line. A dropped dirty bit or a missed write-back stays hidden until the line has been evicted and fetched again. Only then does a read return the stale nibble, so eviction and refetch sequences are exercised on purpose. A wrong busy counter appears directly as a dram_busy run that is not 28 cycles long, or as a second miss accepted too early.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
    localparam int NIB_W    = 4;
    localparam int OFF_W    = 4;
    localparam int LINE_NIB = 1 << OFF_W;
    localparam int LINE_W   = LINE_NIB * NIB_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctrl_state_e;

    function automatic nib_t get_nib(input line_t ln, input logic [OFF_W-1:0] off);
        return ln[off*NIB_W +: NIB_W];
    endfunction

    function automatic line_t put_nib(input line_t ln, input logic [OFF_W-1:0] off,
                                      input nib_t v);
        line_t r;
        r = ln;
        r[off*NIB_W +: NIB_W] = v;
        return r;
    endfunction
endpackage

// File: rtl/cdram_tag_store.sv
module cdram_tag_store
    import cdram_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (upd_en) begin
            valid_q[upd_idx] <= 1'b1;
            dirty_q[upd_idx] <= upd_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) tag_q[upd_idx] <= upd_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cdram_line_sram.sv
module cdram_line_sram
    import cdram_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  line_t            wr_line
);
    localparam int LINES = 1 << IDX_W;

    line_t mem_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[idx] <= wr_line;
    end

    assign rd_line = mem_q[idx];
endmodule

// File: rtl/cdram_dram_array.sv
module cdram_dram_array
    import cdram_pkg::*;
#(
    parameter int LA_W     = 10,
    parameter int DRAM_CYC = 28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LA_W-1:0] rd_addr,
    output line_t           rd_line,
    input  logic            wr_en,
    input  logic [LA_W-1:0] wr_addr,
    input  line_t           wr_line,
    input  logic            start,
    output logic            busy
);
    localparam int NLINES = 1 << LA_W;
    localparam int BCW    = $clog2(DRAM_CYC + 1);
    localparam logic [BCW-1:0] BUSY_LOAD = BCW'(DRAM_CYC);

    line_t          arr_q [NLINES];
    logic [BCW-1:0] busy_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) arr_q[i] <= '0;
        end else if (wr_en) begin
            arr_q[wr_addr] <= wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  busy_cnt_q <= '0;
        else if (start)           busy_cnt_q <= BUSY_LOAD;
        else if (busy_cnt_q != 0) busy_cnt_q <= busy_cnt_q - 1'b1;
    end

    assign rd_line = arr_q[rd_addr];
    assign busy    = (busy_cnt_q != '0);
endmodule

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
    import cdram_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int IDX_W    = 8,
    parameter int MISS_LAT = 7,
    parameter int DRAM_CYC = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NIB_W-1:0]  req_wdata,
    output logic              resp_valid,
    output logic [NIB_W-1:0]  resp_rdata,
    output logic              dram_busy
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int LA_W  = ADDR_W - OFF_W;
    localparam int FCW   = $clog2(MISS_LAT);
    localparam logic [FCW-1:0] FILL_LAST = FCW'(MISS_LAT - 1);

    ctrl_state_e state_q;
    logic [FCW-1:0]    fcnt_q;
    logic [ADDR_W-1:0] h_addr_q;
    logic              h_we_q;
    nib_t              h_wdata_q;

    logic [OFF_W-1:0] r_off, h_off;
    logic [IDX_W-1:0] r_idx, h_idx, cur_idx;
    logic [TAG_W-1:0] r_tag, h_tag;

    assign r_off = req_addr[OFF_W-1:0];
    assign r_idx = req_addr[OFF_W +: IDX_W];
    assign r_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign h_off = h_addr_q[OFF_W-1:0];
    assign h_idx = h_addr_q[OFF_W +: IDX_W];
    assign h_tag = h_addr_q[ADDR_W-1 -: TAG_W];

    assign cur_idx = (state_q == ST_FILL) ? h_idx : r_idx;

    logic             t_valid, t_dirty;
    logic [TAG_W-1:0] t_tag;
    line_t            s_line, d_line;
    logic             lk_hit, fire, fill_done, hit_fire;
    logic             tag_upd, sram_we, dram_we;
    line_t            sram_wline;

    assign lk_hit    = t_valid && (t_tag == r_tag);
    assign req_ready = (state_q == ST_IDLE) && (lk_hit || !dram_busy);
    assign fire      = req_valid && req_ready;
    assign hit_fire  = fire && lk_hit;
    assign fill_done = (state_q == ST_FILL) && (fcnt_q == FILL_LAST);

    assign sram_we    = fill_done || (hit_fire && req_we);
    assign tag_upd    = sram_we;
    assign dram_we    = fill_done && t_valid && t_dirty;
    assign sram_wline = fill_done ? (h_we_q ? put_nib(d_line, h_off, h_wdata_q) : d_line)
                                  : put_nib(s_line, r_off, req_wdata);

    cdram_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (cur_idx),
        .rd_valid  (t_valid),
        .rd_dirty  (t_dirty),
        .rd_tag    (t_tag),
        .upd_en    (tag_upd),
        .upd_idx   (cur_idx),
        .upd_tag   (fill_done ? h_tag : r_tag),
        .upd_dirty (fill_done ? h_we_q : 1'b1)
    );

    cdram_line_sram #(.IDX_W(IDX_W)) u_sram (
        .clk     (clk),
        .idx     (cur_idx),
        .rd_line (s_line),
        .wr_en   (sram_we),
        .wr_line (sram_wline)
    );

    cdram_dram_array #(.LA_W(LA_W), .DRAM_CYC(DRAM_CYC)) u_dram (
        .clk     (clk),
        .rst     (rst),
        .rd_addr ({h_tag, h_idx}),
        .rd_line (d_line),
        .wr_en   (dram_we),
        .wr_addr ({t_tag, h_idx}),
        .wr_line (s_line),
        .start   (fire && !lk_hit),
        .busy    (dram_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            fcnt_q     <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            h_addr_q   <= '0;
            h_we_q     <= 1'b0;
            h_wdata_q  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (hit_fire) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= req_we ? req_wdata : get_nib(s_line, r_off);
                    end else if (fire) begin
                        state_q   <= ST_FILL;
                        fcnt_q    <= FCW'(1);
                        h_addr_q  <= req_addr;
                        h_we_q    <= req_we;
                        h_wdata_q <= req_wdata;
                    end
                end
                ST_FILL: begin
                    fcnt_q <= fcnt_q + 1'b1;
                    if (fill_done) begin
                        state_q    <= ST_IDLE;
                        resp_valid <= 1'b1;
                        resp_rdata <= h_we_q ? h_wdata_q : get_nib(d_line, h_off);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cdram_ctrl_chk.sv
module cdram_ctrl_chk #(
    parameter int MISS_LAT = 7
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic dram_busy,
    input logic lk_hit
);
    localparam int CW = $clog2(MISS_LAT + 1);

    logic          pend_q;
    logic [CW-1:0] pcnt_q;
    logic          acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            pcnt_q <= '0;
        end else if (acc && !lk_hit) begin
            pend_q <= 1'b1;
            pcnt_q <= CW'(1);
        end else if (pend_q) begin
            if (pcnt_q == CW'(MISS_LAT - 1)) pend_q <= 1'b0;
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc && lk_hit |=> resp_valid); // R2
    AST_MISS_NO_EARLY_RESP: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !resp_valid); // R3
    AST_MISS_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !req_ready); // R3
    AST_MISS_RESP_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> resp_valid); // R3
    AST_MISS_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        acc && !lk_hit |=> dram_busy); // R5
    AST_NO_MISS_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        acc && dram_busy |-> lk_hit); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !resp_valid && !dram_busy); // R8
endmodule

bind cdram_ctrl cdram_ctrl_chk #(.MISS_LAT(MISS_LAT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .dram_busy  (dram_busy),
    .lk_hit     (lk_hit)
);

// File: tb/tb_cdram_ctrl.sv
module tb_cdram_ctrl;
    localparam int PERIOD = 10;
    localparam int AW     = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_wdata = '0;
    logic          resp_valid;
    logic [3:0]    resp_rdata;
    logic          dram_busy;

    int total = 0;
    int bad   = 0;
    logic [3:0] ref_mem [1 << AW];
    int run_len = 0;
    int last_run = 0;

    always #(PERIOD/2) clk = ~clk;

    cdram_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .dram_busy(dram_busy)
    );

    always @(negedge clk) begin
        if (dram_busy) run_len <= run_len + 1;
        else if (run_len != 0) begin
            last_run <= run_len;
            run_len  <= 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [AW-1:0] a, input logic [3:0] wd,
                          output logic [3:0] rd, output int lat, output int waits,
                          output logic busy_acc);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        waits = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1; waits++;
        end
        busy_acc = dram_busy;
        @(posedge clk);
        lat = 0;
        rd  = 4'h0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (resp_valid) begin rd = resp_rdata; break; end
            if (lat > 100) break;
        end
        if (we) ref_mem[a] = wd;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input int exp_lat, input string tag);
        logic [3:0] d; int lat; int w; logic b;
        do_req(1'b0, a, 4'h0, d, lat, w, b);
        check({tag, " data"}, d, ref_mem[a]);
        check({tag, " latency"}, lat, exp_lat);
    endtask

    task automatic wr_chk(input logic [AW-1:0] a, input logic [3:0] v, input int exp_lat,
                          input string tag);
        logic [3:0] d; int lat; int w; logic b;
        do_req(1'b1, a, v, d, lat, w, b);
        check({tag, " R9 echo"}, d, v);
        check({tag, " R9 latency"}, lat, exp_lat);
    endtask

    task automatic wait_idle();
        while (dram_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check("R8 resp_valid after reset", resp_valid, 0);
        check("R8 dram_busy after reset", dram_busy, 0);
        check("R8 req_ready after reset", req_ready, 1);
    endtask

    task automatic t_first_miss_and_line();
        rd_chk(14'h0123, 7, "R8 R3 R1 first access miss");
        rd_chk(14'h0120, 1, "R4 R2 same line offset 0");
        rd_chk(14'h012F, 1, "R4 R2 same line offset 15");
        rd_chk(14'h0125, 1, "R4 R2 same line offset 5");
    endtask

    task automatic t_busy_window();
        logic [3:0] d; int lat; int w; logic b;
        wait_idle();
        rd_chk(14'h0400, 7, "R3 miss");
        do_req(1'b0, 14'h0407, 4'h0, d, lat, w, b);
        check("R5 hit accepted while busy", b, 1);
        check("R5 hit latency while busy", lat, 1);
        wait_idle();
        check("R5 busy run length", last_run, 28);
    endtask

    task automatic t_miss_while_busy();
        logic [3:0] d; int lat; int w; logic b;
        wait_idle();
        rd_chk(14'h0800, 7, "R3 miss A");
        do_req(1'b0, 14'h0900, 4'h0, d, lat, w, b);
        check("R6 second miss waited", (w > 0) ? 1 : 0, 1);
        check("R6 busy low at second miss accept", b, 0);
        check("R6 second miss latency", lat, 7);
        check("R6 second miss data", d, ref_mem[14'h0900]);
    endtask

    task automatic t_write_hit();
        wr_chk(14'h0903, 4'hA, 1, "R2 write hit");
        rd_chk(14'h0903, 1, "R1 readback after write hit");
        rd_chk(14'h0904, 1, "R1 neighbour untouched");
    endtask

    task automatic t_writeback();
        wait_idle();
        wr_chk(14'h0555, 4'h9, 7, "R7 write miss");
        wr_chk(14'h055E, 4'h3, 1, "R7 write hit dirty line");
        wait_idle();
        rd_chk(14'h1555, 7, "R7 evicting read");
        wait_idle();
        rd_chk(14'h0555, 7, "R7 refetched written nibble");
        rd_chk(14'h055E, 1, "R7 second written nibble");
        rd_chk(14'h0556, 1, "R7 unwritten nibble");
        wait_idle();
        rd_chk(14'h2555, 7, "R7 clean eviction read");
        wait_idle();
        rd_chk(14'h0555, 7, "R7 data survives clean eviction");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] a;
            a = AW'(14'h0A00 + i * 14'h1010 + i);
            wait_idle();
            wr_chk(a, 4'(i + 5), 7, "R9 sweep write miss");
        end
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] a;
            a = AW'(14'h0A00 + i * 14'h1010 + i);
            rd_chk(a, 1, "R1 sweep readback");
        end
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_miss_and_line();
        t_busy_window();
        t_miss_while_busy();
        t_write_hit();
        t_writeback();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule